// File: doc/BRIEF.md
# Crossover-Searching Link Resolver

This controller brings up a copper port whose wire pairs may be straight or crossed. After a start pulse it waits a fixed retry delay, measured in pulses of a slow timebase tick, and then asks the PHY for its basic status register. If the link bit is clear, it flips the crossover select between straight (MDI) and crossed (MDIX) pair assignment and tries again. This repeats until link appears or the attempt budget runs out.

Once link is seen, the controller reads a chain of PHY registers through a simple request/done port, which a separate serial management engine serves. Each read depends on the one before it. From these reads it resolves the line speed, the duplex mode and whether pause frames were agreed with the link partner. The result is published as a four-bit port status word, together with a done flag. Running out of attempts raises a fail flag instead and leaves the status word untouched.

Top module: `mdix_link_ctl`

## Requirements
- R1: After reset, mdixSel, statusWord, linkDone, linkFail and mdioReq are all 0, and no request is issued until start is pulsed.
- R2: A start pulse seen while idle clears linkDone and linkFail and forces mdixSel to 0 (MDI) on the same clock edge. The retry delay begins on the next cycle.
- R3: Before every link check the block counts exactly DELAY_TICKS tick pulses while waiting. The request appears in the cycle after the edge that samples the last of those ticks.
- R4: A link check reads PHY register 1. If bit 2 of the returned data is 1, link is up. Otherwise mdixSel toggles on the edge that samples mdioDone, and a new delay starts. Check n (counting from 0) therefore runs with mdixSel equal to n mod 2.
- R5: After MAX_TRIES link checks that all fail, linkFail is set and linkDone stays 0. The statusWord keeps its earlier value, and no further request is made.
- R6: After link is up, register 1 is read a second time. If bit 5 of that read is 0, the block publishes statusWord = 4'b1000 and makes no further reads.
- R7: If bit 5 is 1, register 31 is read and its bits 4:2 are decoded. Code 1 gives speed=0 and duplex=0. Code 5 gives speed=0 and duplex=1. Code 2 gives speed=1 and duplex=0. Code 6 gives speed=1 and duplex=1. Any other code gives 0 for both.
- R8: After register 31, the pause chain runs only while each condition holds, in this order. Register 1 bit 3 set leads to a read of register 6. Register 6 bit 0 set leads to a read of register 4. Register 4 bit 10 set leads to a read of register 5. Register 5 bit 10 set sets the pause bit. The chain stops at the first condition that is 0.
- R9: statusWord bit 0 is speed, bit 1 is duplex, bit 2 is pause and bit 3 is link. It is registered and changes only when a successful run publishes. Bit 3 is 1 whenever it is published. linkDone rises on the same edge, one cycle after the final read's mdioDone is sampled.
- R10: mdioReq, once raised, stays high with mdioRegAddr stable until mdioDone is sampled. The read data is taken in the cycle in which mdioDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a link search |
| tick | input | 1 | Timebase pulse that paces the retry delay |
| mdioRdData | input | DATA_W | Register data returned with mdioDone |
| mdioDone | input | 1 | One-cycle pulse completing the current read |
| mdioReq | output | 1 | Read request to the management engine |
| mdioRegAddr | output | 5 | PHY register address of the current read |
| mdixSel | output | 1 | Crossover select, 0 = MDI, 1 = MDIX |
| statusWord | output | 4 | Resolved port status {link, pause, duplex, speed} |
| linkDone | output | 1 | Level, set when a search succeeds |
| linkFail | output | 1 | Level, set when the attempt budget is exhausted |

## Verification
Each link-check request is due in the cycle after the edge that samples the DELAY_TICKS-th tick. The bench counts ticks at every edge where no request is pending and resets that count on start and on mdioDone, then compares the count at the falling edge where the request is first seen. The crossover select changes on the edge that samples a failing mdioDone. It is compared against the parity of the check index at each later request. The status word and the done or fail flag settle one cycle after the last mdioDone, so the bench waits on those levels at falling edges. It then compares the status word with a value computed from the register contents of its PHY model, and the number of reads with the expected length of the dependent chain.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

  localparam int REG_ADDR_W = 5;

  // PHY register addresses read by the resolver
  localparam logic [REG_ADDR_W-1:0] PHY_REG_BASIC   = 5'd1;
  localparam logic [REG_ADDR_W-1:0] PHY_REG_ADV     = 5'd4;
  localparam logic [REG_ADDR_W-1:0] PHY_REG_PARTNER = 5'd5;
  localparam logic [REG_ADDR_W-1:0] PHY_REG_EXPN    = 5'd6;
  localparam logic [REG_ADDR_W-1:0] PHY_REG_MODE    = 5'd31;

  // Bit positions inside the returned data
  localparam int BIT_LINK_UP     = 2;
  localparam int BIT_NEG_ABLE    = 3;
  localparam int BIT_RESOLVED    = 5;
  localparam int BIT_PARTNER_NEG = 0;
  localparam int BIT_PAUSE_CAP   = 10;
  localparam int MODE_LSB        = 2;
  localparam int MODE_W          = 3;

  // Operating mode codes found in the mode register field
  localparam logic [MODE_W-1:0] MODE_10_HALF  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_10_FULL  = 3'd5;
  localparam logic [MODE_W-1:0] MODE_100_HALF = 3'd2;
  localparam logic [MODE_W-1:0] MODE_100_FULL = 3'd6;

  // Status word layout
  localparam int STATUS_W   = 4;
  localparam int ST_SPEED   = 0;
  localparam int ST_DUPLEX  = 1;
  localparam int ST_PAUSE   = 2;
  localparam int ST_LINK    = 3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DELAY,
    S_LINK,
    S_BASIC,
    S_MODE,
    S_EXPN,
    S_ADV,
    S_PART,
    S_POST
  } linkState_t;

  typedef struct packed {
    logic clrRun;
    logic delayRun;
    logic tryInc;
    logic toggleSel;
    logic failSet;
    logic latchBasic;
    logic latchMode;
    logic setPause;
    logic publish;
  } ctlStrobe_t;

endpackage

// File: rtl/mdix_ctrl.sv
module mdix_ctrl
  import mdix_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  mdioDone,
  input  logic [DATA_W-1:0]     mdioRdData,
  input  logic                  delayHit,
  input  logic                  triesLast,
  input  logic                  negAble,
  output logic                  mdioReq,
  output logic [REG_ADDR_W-1:0] mdioRegAddr,
  output ctlStrobe_t            strb
);

  linkState_t state, stateNext;

  logic unusedRdBits;
  assign unusedRdBits = ^mdioRdData;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.clrRun = 1'b1;
          stateNext   = S_DELAY;
        end
      end
      S_DELAY: begin
        strb.delayRun = 1'b1;
        if (delayHit) stateNext = S_LINK;
      end
      S_LINK: begin
        if (mdioDone) begin
          if (mdioRdData[BIT_LINK_UP]) begin
            stateNext = S_BASIC;
          end else begin
            strb.toggleSel = 1'b1;
            if (triesLast) begin
              strb.failSet = 1'b1;
              stateNext    = S_IDLE;
            end else begin
              strb.tryInc = 1'b1;
              stateNext   = S_DELAY;
            end
          end
        end
      end
      S_BASIC: begin
        if (mdioDone) begin
          strb.latchBasic = 1'b1;
          stateNext = mdioRdData[BIT_RESOLVED] ? S_MODE : S_POST;
        end
      end
      S_MODE: begin
        if (mdioDone) begin
          strb.latchMode = 1'b1;
          stateNext = negAble ? S_EXPN : S_POST;
        end
      end
      S_EXPN: begin
        if (mdioDone) stateNext = mdioRdData[BIT_PARTNER_NEG] ? S_ADV : S_POST;
      end
      S_ADV: begin
        if (mdioDone) stateNext = mdioRdData[BIT_PAUSE_CAP] ? S_PART : S_POST;
      end
      S_PART: begin
        if (mdioDone) begin
          strb.setPause = mdioRdData[BIT_PAUSE_CAP];
          stateNext     = S_POST;
        end
      end
      S_POST: begin
        strb.publish = 1'b1;
        stateNext    = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    mdioReq     = 1'b1;
    mdioRegAddr = PHY_REG_BASIC;
    case (state)
      S_LINK:  mdioRegAddr = PHY_REG_BASIC;
      S_BASIC: mdioRegAddr = PHY_REG_BASIC;
      S_MODE:  mdioRegAddr = PHY_REG_MODE;
      S_EXPN:  mdioRegAddr = PHY_REG_EXPN;
      S_ADV:   mdioRegAddr = PHY_REG_ADV;
      S_PART:  mdioRegAddr = PHY_REG_PARTNER;
      default: mdioReq     = 1'b0;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReq && !mdioDone) |=> (mdioReq && $stable(mdioRegAddr))); // R10

  AST_CHECK_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LINK && $past(state) == S_DELAY) |-> $past(delayHit)); // R3

endmodule

// File: rtl/mdix_dp.sv
module mdix_dp
  import mdix_pkg::*;
#(
  parameter int DELAY_TICKS = 2000,
  parameter int MAX_TRIES   = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [MODE_W-1:0]   modeField,
  input  logic                negBit,
  input  ctlStrobe_t          strb,
  output logic                delayHit,
  output logic                triesLast,
  output logic                negAble,
  output logic                mdixSel,
  output logic [STATUS_W-1:0] statusWord,
  output logic                doneFlag,
  output logic                failFlag
);

  localparam int DLY_W = $clog2(DELAY_TICKS + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_TICKS - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

  logic [DLY_W-1:0] dlyCnt;
  logic [TRY_W-1:0] tryCnt;
  logic             accSpeed, accDuplex, accPause;
  logic             decSpeed, decDuplex;

  assign delayHit  = strb.delayRun && tick && (dlyCnt == DLY_LAST);
  assign triesLast = (tryCnt == TRY_LAST);

  // retry delay counter, idle at zero outside the wait state
  always_ff @(posedge clk) begin
    if (!rstN)                              dlyCnt <= '0;
    else if (!strb.delayRun || delayHit)    dlyCnt <= '0;
    else if (tick)                          dlyCnt <= dlyCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             tryCnt <= '0;
    else if (strb.clrRun)  tryCnt <= '0;
    else if (strb.tryInc)  tryCnt <= tryCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               mdixSel <= 1'b0;
    else if (strb.clrRun)    mdixSel <= 1'b0;
    else if (strb.toggleSel) mdixSel <= ~mdixSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                negAble <= 1'b0;
    else if (strb.clrRun)     negAble <= 1'b0;
    else if (strb.latchBasic) negAble <= negBit;
  end

  always_comb begin
    decSpeed  = 1'b0;
    decDuplex = 1'b0;
    case (modeField)
      MODE_10_HALF:  ;
      MODE_10_FULL:  decDuplex = 1'b1;
      MODE_100_HALF: decSpeed  = 1'b1;
      MODE_100_FULL: begin decSpeed = 1'b1; decDuplex = 1'b1; end
      default:       ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accSpeed  <= 1'b0;
      accDuplex <= 1'b0;
      accPause  <= 1'b0;
    end else if (strb.clrRun) begin
      accSpeed  <= 1'b0;
      accDuplex <= 1'b0;
      accPause  <= 1'b0;
    end else begin
      if (strb.latchMode) begin
        accSpeed  <= decSpeed;
        accDuplex <= decDuplex;
      end
      if (strb.setPause) accPause <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord <= '0;
    end else if (strb.publish) begin
      statusWord[ST_SPEED]  <= accSpeed;
      statusWord[ST_DUPLEX] <= accDuplex;
      statusWord[ST_PAUSE]  <= accPause;
      statusWord[ST_LINK]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      failFlag <= 1'b0;
    end else if (strb.clrRun) begin
      doneFlag <= 1'b0;
      failFlag <= 1'b0;
    end else begin
      if (strb.publish) doneFlag <= 1'b1;
      if (strb.failSet) failFlag <= 1'b1;
    end
  end

  AST_TOGGLE_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    strb.toggleSel |=> (mdixSel != $past(mdixSel))); // R4

  AST_START_MDI: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRun |=> (!mdixSel && !doneFlag && !failFlag)); // R2

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(statusWord)); // R9

  AST_LINK_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> statusWord[ST_LINK]); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(doneFlag && failFlag)); // R5

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt < TRY_W'(MAX_TRIES)); // R5

endmodule

// File: rtl/mdix_link_ctl.sv
module mdix_link_ctl
  import mdix_pkg::*;
#(
  parameter int DELAY_TICKS = 2000,
  parameter int MAX_TRIES   = 100,
  parameter int DATA_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  tick,
  input  logic [DATA_W-1:0]     mdioRdData,
  input  logic                  mdioDone,
  output logic                  mdioReq,
  output logic [REG_ADDR_W-1:0] mdioRegAddr,
  output logic                  mdixSel,
  output logic [STATUS_W-1:0]   statusWord,
  output logic                  linkDone,
  output logic                  linkFail
);

  ctlStrobe_t strb;
  logic       delayHit, triesLast, negAble;

  mdix_ctrl #(
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .mdioDone   (mdioDone),
    .mdioRdData (mdioRdData),
    .delayHit   (delayHit),
    .triesLast  (triesLast),
    .negAble    (negAble),
    .mdioReq    (mdioReq),
    .mdioRegAddr(mdioRegAddr),
    .strb       (strb)
  );

  mdix_dp #(
    .DELAY_TICKS(DELAY_TICKS),
    .MAX_TRIES  (MAX_TRIES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .modeField (mdioRdData[MODE_LSB +: MODE_W]),
    .negBit    (mdioRdData[BIT_NEG_ABLE]),
    .strb      (strb),
    .delayHit  (delayHit),
    .triesLast (triesLast),
    .negAble   (negAble),
    .mdixSel   (mdixSel),
    .statusWord(statusWord),
    .doneFlag  (linkDone),
    .failFlag  (linkFail)
  );

endmodule

// File: tb/mdix_link_ctl_test.sv
module mdix_link_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DT  = 3;
  localparam int MT  = 5;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] mdioRdData = 16'h0;
  logic        mdioDone = 1'b0;
  logic        mdioReq;
  logic [4:0]  mdioRegAddr;
  logic        mdixSel;
  logic [3:0]  statusWord;
  logic        linkDone, linkFail;

  mdix_link_ctl #(.DELAY_TICKS(DT), .MAX_TRIES(MT), .DATA_W(16)) uut (
    .clk(clk), .rstN(rstN), .start(start), .tick(tick),
    .mdioRdData(mdioRdData), .mdioDone(mdioDone),
    .mdioReq(mdioReq), .mdioRegAddr(mdioRegAddr), .mdixSel(mdixSel),
    .statusWord(statusWord), .linkDone(linkDone), .linkFail(linkFail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // PHY model state
  int mCode = 0;
  bit mB5 = 0, mB3 = 0, mB6 = 0, mB4 = 0, mBp = 0;
  int linkAfter = 0;
  int linkChecks = 0;
  int readCount = 0;
  bit linkPhase = 0;
  int tickCnt = 0;

  always @(posedge clk) begin
    if (start || mdioDone) tickCnt <= 0;
    else if (tick && !mdioReq) tickCnt <= tickCnt + 1;
  end

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // MDIO responder
  logic [4:0]  rAddr;
  logic [15:0] rData;
  bit          up;
  initial forever begin
    @(negedge clk);
    if (rstN && mdioReq) begin
      rAddr = mdioRegAddr;
      if (rAddr == 5'd1 && linkPhase) begin
        chk(tickCnt == DT, "R3 ticks before link check", tickCnt, DT);
        chk(int'(mdixSel) == linkChecks % 2, "R4 crossover at check", int'(mdixSel), linkChecks % 2);
      end
      repeat (LAT) begin
        @(negedge clk);
        chk(mdioReq && mdioRegAddr == rAddr, "R10 request held", int'(mdioRegAddr), int'(rAddr));
      end
      case (rAddr)
        5'd1: begin
          if (linkPhase) begin
            up = (linkChecks >= linkAfter);
            rData = up ? 16'h0004 : 16'h0028;
            linkChecks++;
            if (up) linkPhase = 0;
          end else begin
            rData = 16'h0004 | (16'(mB5) << 5) | (16'(mB3) << 3);
          end
        end
        5'd31: rData = 16'hF003 | (16'(mCode) << 2);
        5'd6:  rData = 16'h00F0 | 16'(mB6);
        5'd4:  rData = 16'h01E1 | (16'(mB4) << 10);
        5'd5:  rData = 16'h0801 | (16'(mBp) << 10);
        default: rData = 16'h0000;
      endcase
      mdioRdData = rData;
      mdioDone   = 1'b1;
      readCount++;
      @(negedge clk);
      mdioDone   = 1'b0;
      mdioRdData = 16'h0;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  task automatic runCase(input int code, input bit b5, input bit b3, input bit b6,
                         input bit b4, input bit bp, input int la, input bit expFail);
    logic [3:0] prev;
    logic [3:0] expSt;
    int expReads;
    int w;
    bit spd, dup, pau;
    mCode = code; mB5 = b5; mB3 = b3; mB6 = b6; mB4 = b4; mBp = bp;
    linkAfter = la; linkChecks = 0; readCount = 0; linkPhase = 1;
    prev = statusWord;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!linkDone && !linkFail, "R2 flags cleared at start", int'({linkDone, linkFail}), 0);
    chk(mdixSel == 1'b0, "R2 MDI at start", int'(mdixSel), 0);
    w = 0;
    while (!linkDone && !linkFail && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (expFail) begin
      chk(linkFail == 1'b1, "R5 fail raised", int'(linkFail), 1);
      chk(linkDone == 1'b0, "R5 no done on fail", int'(linkDone), 0);
      chk(statusWord == prev, "R5 status kept on fail", int'(statusWord), int'(prev));
      chk(linkChecks == MT, "R5 number of link checks", linkChecks, MT);
      chk(readCount == MT, "R5 no reads beyond checks", readCount, MT);
      chk(int'(mdixSel) == MT % 2, "R4 crossover after last miss", int'(mdixSel), MT % 2);
    end else begin
      spd = 0; dup = 0;
      if (b5) begin
        case (code)
          1: begin spd = 0; dup = 0; end
          5: begin spd = 0; dup = 1; end
          2: begin spd = 1; dup = 0; end
          6: begin spd = 1; dup = 1; end
          default: begin spd = 0; dup = 0; end
        endcase
      end
      pau = b5 & b3 & b6 & b4 & bp;
      expSt = {1'b1, pau, dup, spd};
      expReads = la + 2;
      if (b5) begin
        expReads++;
        if (b3) begin
          expReads++;
          if (b6) begin
            expReads++;
            if (b4) expReads++;
          end
        end
      end
      chk(linkDone == 1'b1 && linkFail == 1'b0, "R9 done raised", int'({linkDone, linkFail}), 2);
      chk(statusWord == expSt, "R6 R7 R8 R9 status word", int'(statusWord), int'(expSt));
      chk(readCount == expReads, "R6 R8 read chain length", readCount, expReads);
      chk(int'(mdixSel) == la % 2, "R4 crossover at link", int'(mdixSel), la % 2);
    end
    repeat (4) @(negedge clk);
    chk(!mdioReq, "R5 R6 no request after outcome", int'(mdioReq), 0);
    chk(statusWord == (expFail ? prev : expSt), "R9 status stable after outcome", int'(statusWord),
        int'(expFail ? prev : expSt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mdixSel == 1'b0, "R1 reset mdixSel", int'(mdixSel), 0);
    chk(statusWord == 4'h0, "R1 reset statusWord", int'(statusWord), 0);
    chk(!linkDone && !linkFail, "R1 reset flags", int'({linkDone, linkFail}), 0);
    chk(!mdioReq, "R1 reset request", int'(mdioReq), 0);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    chk(!mdioReq, "R1 no request before start", int'(mdioReq), 0);

    for (int code = 0; code < 8; code++) begin
      for (int b5 = 0; b5 < 2; b5++) begin
        for (int p = 0; p < 16; p++) begin
          runCase(code, b5[0], p[0], p[1], p[2], p[3], (code + p + b5) % 4, 1'b0);
        end
      end
    end
    runCase(6, 1, 1, 1, 1, 1, MT - 1, 1'b0);
    runCase(2, 1, 0, 0, 0, 0, 1000, 1'b1);
    runCase(5, 1, 1, 1, 1, 0, 2, 1'b0);

    summary();
    $finish;
  end

endmodule